// File: doc/BRIEF.md
# Thermal Derating Policy Controller

This block turns a stream of temperature readings from one decision sensor into a throttling policy. Each accepted reading is checked against a warning level, a derate level and a recovery level. The block also works out how far the temperature moved since the previous reading and keeps a leaky count of trigger events. From these inputs it steps through a four-rung ladder: normal, warning, derate and recovery.

Each rung drives a set of caps that the surrounding datapath enforces. These are an internal-effort cap, a slowed retry rate, a ceiling on active lanes and a cooldown request. Every move between rungs produces a one-cycle record for logging. The record holds the old rung, the new rung and the cause. A saturating counter of derate entries lets the oscillation rate be audited over time.

Nothing changes between readings. All timing windows are counted in readings, not in clock cycles. This keeps the policy independent of the system clock.

Top module: `thermal_policy_ctrl`

## Requirements
- R1: After reset the rung is normal (code 0), lane_cap equals LANES, effort_cap, retry_slow, cooldown_en and evt_vld are 0, and derate_cycles is 0.
- R2: In normal, a reading at or above cfg_warn moves to warning (code 1) with cause 0 (level). Otherwise, a rise at or above cfg_rise_lim moves to warning with cause 1 (slope). The rise is the signed difference from the previous reading, and it is 0 for the first reading after reset.
- R3: In warning, a reading at or above cfg_derate moves to derate (code 2) with cause 0. Derate is entered only from warning.
- R4: In warning, when neither escalation applies, a reading at or below cfg_warn minus cfg_hyst returns to normal with cause 0.
- R5: A reading is a trigger when it is at or above cfg_warn or its rise is at or above cfg_rise_lim. At the last reading of each WIN_SMP-reading window the repeat count first drops by 1 if it is nonzero. It then rises by 1 for a trigger, saturating at its maximum. The window restarts on every entry to warning. In warning, an updated count at or above cfg_rep_max moves to derate with cause 2 (repeat). A level escalation takes priority over this.
- R6: In derate, HOLD_SMP consecutive readings that are at or below cfg_recover minus cfg_hyst, each with a rise below cfg_rise_lim, move to recovery (code 3) with cause 0. Any other reading restarts the hold count. Recovery is entered only from derate.
- R7: In recovery, a reading at or above cfg_warn moves to warning with cause 0. Otherwise, any positive rise moves to warning with cause 1.
- R8: In recovery, once STABLE_SMP readings have been spent there and the updated repeat count is below cfg_decay_th, the rung returns to normal with cause 3 (timer).
- R9: effort_cap is set in every rung except normal. retry_slow is set in warning and derate. cooldown_en is set in derate while the repeat count is at or above cfg_rep_max. lane_cap is DERATE_LANES in derate and on entry to recovery, and rises by 1 per further recovery reading up to LANES. In normal and warning it is LANES.
- R10: derate_cycles increments by 1 on each entry to derate and saturates at its maximum.
- R11: Every rung change raises evt_vld for exactly one cycle, with evt_old, evt_new and evt_why giving the old rung, the new rung and the cause. Without a change evt_vld stays 0.
- R12: Cycles without samp_vld leave the rung, caps, counters and events unchanged, whatever samp_temp holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_vld | input | 1 | A new temperature reading is present this cycle |
| samp_temp | input | TW | Signed temperature reading |
| cfg_warn | input | TW | Signed warning level |
| cfg_derate | input | TW | Signed derate level |
| cfg_recover | input | TW | Signed recovery level |
| cfg_hyst | input | TW | Hysteresis subtracted from the warning and recovery levels |
| cfg_rise_lim | input | TW | Signed rise limit per reading |
| cfg_rep_max | input | REP_W | Repeat count that escalates warning to derate |
| cfg_decay_th | input | REP_W | Repeat count must be below this to leave recovery |
| effort_cap | output | 1 | Cap on internal effort |
| retry_slow | output | 1 | Reduced retry rate |
| lane_cap | output | clog2(LANES+1) | Ceiling on active lanes |
| cooldown_en | output | 1 | Cooldown request |
| state_o | output | 2 | Current rung (0 normal, 1 warning, 2 derate, 3 recovery) |
| derate_cycles | output | CYC_W | Saturating count of derate entries |
| evt_vld | output | 1 | One-cycle transition strobe |
| evt_old | output | 2 | Rung before the transition |
| evt_new | output | 2 | Rung after the transition |
| evt_why | output | 2 | Cause: 0 level, 1 slope, 2 repeat, 3 timer |

## Verification
Several escalation causes can hold on the same reading. The most telling cases are a reading that reaches the derate level just as the repeat count reaches cfg_rep_max, and a repeat-window decay that lands on a reading that is itself a trigger. The bench creates these collisions in two ways. It drives directed ramps whose repeat count is already one below the limit, and it runs a long pseudo-random walk of readings with gaps between them. A behavioural reference model predicts the rung, the caps, the counter and the event fields for every clock. The bench compares them all on every cycle, so a wrong priority shows up as a mismatch in the cause code or the rung.

// File: rtl/tp_pkg.sv
package tp_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_WARN   = 2'd1,
        ST_DERATE = 2'd2,
        ST_RECOV  = 2'd3
    } tp_state_e;

    typedef enum logic [1:0] {
        WHY_LEVEL  = 2'd0,
        WHY_SLOPE  = 2'd1,
        WHY_REPEAT = 2'd2,
        WHY_TIMER  = 2'd3
    } tp_why_e;
endpackage

// File: rtl/tp_trend.sv
module tp_trend #(
    parameter int TW      = 10,
    parameter int REP_W   = 4,
    parameter int WIN_SMP = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 samp_vld,
    input  logic signed [TW-1:0] samp_temp,
    input  logic signed [TW-1:0] cfg_warn,
    input  logic signed [TW-1:0] cfg_rise_lim,
    input  logic                 win_clr,
    output logic signed [TW:0]   rise,
    output logic [REP_W-1:0]     rep_nxt,
    output logic [REP_W-1:0]     rep_q
);
    localparam int WIN_W = (WIN_SMP > 1) ? $clog2(WIN_SMP) : 1;
    localparam logic [REP_W-1:0] REP_TOP = '1;

    typedef struct packed {
        logic signed [TW-1:0] prev;
        logic                 pvld;
        logic [REP_W-1:0]     rep;
        logic [WIN_W-1:0]     win;
    } trend_t;

    trend_t q, d;
    logic signed [TW:0] t_ext, warn_ext, lim_ext;
    logic trig, tick;

    assign t_ext    = {samp_temp[TW-1], samp_temp};
    assign warn_ext = {cfg_warn[TW-1], cfg_warn};
    assign lim_ext  = {cfg_rise_lim[TW-1], cfg_rise_lim};
    assign rep_q    = q.rep;

    always_comb begin
        rise = q.pvld ? (t_ext - {q.prev[TW-1], q.prev}) : '0;
        trig = (t_ext >= warn_ext) || (rise >= lim_ext);
        tick = (q.win == WIN_W'(WIN_SMP - 1));
        rep_nxt = q.rep;
        if (tick && rep_nxt != '0) rep_nxt = rep_nxt - 1'b1;
        if (trig && rep_nxt != REP_TOP) rep_nxt = rep_nxt + 1'b1;
        d = q;
        if (samp_vld) begin
            d.prev = samp_temp;
            d.pvld = 1'b1;
            d.rep  = rep_nxt;
            d.win  = (win_clr || tick) ? '0 : q.win + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_REP_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld |=> (rep_q == $past(rep_q)) || (rep_q == $past(rep_q) + 1) || (rep_q == $past(rep_q) - 1)); // R5
    AST_REP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_vld |=> $stable(rep_q)); // R12
endmodule

// File: rtl/tp_ladder.sv
module tp_ladder
    import tp_pkg::*;
#(
    parameter int TW           = 10,
    parameter int REP_W        = 4,
    parameter int HOLD_SMP     = 3,
    parameter int STABLE_SMP   = 4,
    parameter int LANES        = 4,
    parameter int DERATE_LANES = 1,
    parameter int CYC_W        = 8,
    localparam int LW          = $clog2(LANES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 samp_vld,
    input  logic signed [TW-1:0] samp_temp,
    input  logic signed [TW:0]   rise,
    input  logic [REP_W-1:0]     rep_nxt,
    input  logic signed [TW-1:0] cfg_warn,
    input  logic signed [TW-1:0] cfg_derate,
    input  logic signed [TW-1:0] cfg_recover,
    input  logic signed [TW-1:0] cfg_hyst,
    input  logic signed [TW-1:0] cfg_rise_lim,
    input  logic [REP_W-1:0]     cfg_rep_max,
    input  logic [REP_W-1:0]     cfg_decay_th,
    output tp_state_e            st_o,
    output logic [LW-1:0]        lane_o,
    output logic [CYC_W-1:0]     cyc_o,
    output logic                 evt_o,
    output logic [1:0]           old_o,
    output logic [1:0]           new_o,
    output logic [1:0]           why_o,
    output logic                 win_clr
);
    localparam int HW = $clog2(HOLD_SMP + 1);
    localparam int SW = $clog2(STABLE_SMP + 1);

    typedef struct packed {
        tp_state_e        st;
        logic [HW-1:0]    hold;
        logic [SW-1:0]    stab;
        logic [LW-1:0]    lane;
        logic [CYC_W-1:0] cyc;
        logic             evt;
        tp_state_e        old;
        tp_state_e        nw;
        tp_why_e          why;
    } ladder_t;

    ladder_t q, d;
    tp_state_e ns;
    tp_why_e   why;
    logic signed [TW:0] t_ext, warn_ext, der_ext, lim_ext, warn_lo, rec_lo;
    logic cool;
    logic [HW-1:0] hold_inc;
    logic [SW-1:0] stab_inc;

    assign t_ext    = {samp_temp[TW-1], samp_temp};
    assign warn_ext = {cfg_warn[TW-1], cfg_warn};
    assign der_ext  = {cfg_derate[TW-1], cfg_derate};
    assign lim_ext  = {cfg_rise_lim[TW-1], cfg_rise_lim};
    assign warn_lo  = warn_ext - {cfg_hyst[TW-1], cfg_hyst};
    assign rec_lo   = {cfg_recover[TW-1], cfg_recover} - {cfg_hyst[TW-1], cfg_hyst};

    always_comb begin
        d        = q;
        d.evt    = 1'b0;
        ns       = q.st;
        why      = WHY_LEVEL;
        cool     = (t_ext <= rec_lo) && (rise < lim_ext);
        hold_inc = cool ? q.hold + 1'b1 : '0;
        stab_inc = (q.stab == SW'(STABLE_SMP)) ? q.stab : q.stab + 1'b1;
        if (samp_vld) begin
            case (q.st)
                ST_NORMAL: begin
                    if (t_ext >= warn_ext)     begin ns = ST_WARN; why = WHY_LEVEL; end
                    else if (rise >= lim_ext)  begin ns = ST_WARN; why = WHY_SLOPE; end
                end
                ST_WARN: begin
                    if (t_ext >= der_ext)               begin ns = ST_DERATE; why = WHY_LEVEL;  end
                    else if (rep_nxt >= cfg_rep_max)    begin ns = ST_DERATE; why = WHY_REPEAT; end
                    else if (t_ext <= warn_lo)          begin ns = ST_NORMAL; why = WHY_LEVEL;  end
                end
                ST_DERATE: begin
                    if (hold_inc == HW'(HOLD_SMP)) begin ns = ST_RECOV; why = WHY_LEVEL; end
                end
                default: begin
                    if (t_ext >= warn_ext)                 begin ns = ST_WARN; why = WHY_LEVEL; end
                    else if (!rise[TW] && rise != '0)      begin ns = ST_WARN; why = WHY_SLOPE; end
                    else if (stab_inc == SW'(STABLE_SMP) && rep_nxt < cfg_decay_th)
                                                           begin ns = ST_NORMAL; why = WHY_TIMER; end
                end
            endcase
            d.st   = ns;
            d.hold = (q.st == ST_DERATE && ns == ST_DERATE) ? hold_inc : '0;
            d.stab = (q.st == ST_RECOV && ns == ST_RECOV) ? stab_inc : '0;
            if (ns == ST_RECOV && q.st == ST_RECOV)
                d.lane = (q.lane == LW'(LANES)) ? q.lane : q.lane + 1'b1;
            else if (ns == ST_RECOV || ns == ST_DERATE)
                d.lane = LW'(DERATE_LANES);
            else
                d.lane = LW'(LANES);
            if (ns == ST_DERATE && q.st != ST_DERATE && q.cyc != '1)
                d.cyc = q.cyc + 1'b1;
            d.evt = (ns != q.st);
            if (ns != q.st) begin
                d.old = q.st;
                d.nw  = ns;
                d.why = why;
            end
        end
    end

    assign win_clr = samp_vld && (ns == ST_WARN) && (q.st != ST_WARN);
    assign st_o    = q.st;
    assign lane_o  = q.lane;
    assign cyc_o   = q.cyc;
    assign evt_o   = q.evt;
    assign old_o   = q.old;
    assign new_o   = q.nw;
    assign why_o   = q.why;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.lane <= LW'(LANES);
        end else begin
            q <= d;
        end
    end

    AST_EVT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (new_o == 2'(st_o)) && (old_o != new_o)); // R11
    AST_EVT_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o != $past(st_o)) |-> evt_o); // R11
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_vld |=> $stable(st_o) && $stable(lane_o) && !evt_o); // R12
    AST_DERATE_FROM_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o == ST_DERATE && $past(st_o) != ST_DERATE) |-> $past(st_o) == ST_WARN); // R3
    AST_RECOV_FROM_DERATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o == ST_RECOV && $past(st_o) != ST_RECOV) |-> $past(st_o) == ST_DERATE); // R6
    AST_LANE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_o >= LW'(DERATE_LANES)) && (lane_o <= LW'(LANES))); // R9
    AST_CYC_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o == ST_DERATE && $past(st_o) != ST_DERATE) |-> (cyc_o == $past(cyc_o) + 1'b1) || (cyc_o == '1)); // R10
endmodule

// File: rtl/thermal_policy_ctrl.sv
module thermal_policy_ctrl
    import tp_pkg::*;
#(
    parameter int TW           = 10,
    parameter int REP_W        = 4,
    parameter int WIN_SMP      = 8,
    parameter int HOLD_SMP     = 3,
    parameter int STABLE_SMP   = 4,
    parameter int LANES        = 4,
    parameter int DERATE_LANES = 1,
    parameter int CYC_W        = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           samp_vld,
    input  logic signed [TW-1:0]           samp_temp,
    input  logic signed [TW-1:0]           cfg_warn,
    input  logic signed [TW-1:0]           cfg_derate,
    input  logic signed [TW-1:0]           cfg_recover,
    input  logic signed [TW-1:0]           cfg_hyst,
    input  logic signed [TW-1:0]           cfg_rise_lim,
    input  logic [REP_W-1:0]               cfg_rep_max,
    input  logic [REP_W-1:0]               cfg_decay_th,
    output logic                           effort_cap,
    output logic                           retry_slow,
    output logic [$clog2(LANES+1)-1:0]     lane_cap,
    output logic                           cooldown_en,
    output logic [1:0]                     state_o,
    output logic [CYC_W-1:0]               derate_cycles,
    output logic                           evt_vld,
    output logic [1:0]                     evt_old,
    output logic [1:0]                     evt_new,
    output logic [1:0]                     evt_why
);
    logic signed [TW:0] rise;
    logic [REP_W-1:0]   rep_nxt, rep_q;
    logic               win_clr;
    tp_state_e          st;

    tp_trend #(.TW(TW), .REP_W(REP_W), .WIN_SMP(WIN_SMP)) i_trend (
        .clk, .rst_n, .samp_vld, .samp_temp, .cfg_warn, .cfg_rise_lim,
        .win_clr, .rise, .rep_nxt, .rep_q
    );

    tp_ladder #(
        .TW(TW), .REP_W(REP_W), .HOLD_SMP(HOLD_SMP), .STABLE_SMP(STABLE_SMP),
        .LANES(LANES), .DERATE_LANES(DERATE_LANES), .CYC_W(CYC_W)
    ) i_ladder (
        .clk, .rst_n, .samp_vld, .samp_temp, .rise, .rep_nxt,
        .cfg_warn, .cfg_derate, .cfg_recover, .cfg_hyst, .cfg_rise_lim,
        .cfg_rep_max, .cfg_decay_th,
        .st_o(st), .lane_o(lane_cap), .cyc_o(derate_cycles),
        .evt_o(evt_vld), .old_o(evt_old), .new_o(evt_new), .why_o(evt_why),
        .win_clr
    );

    assign state_o     = st;
    assign effort_cap  = (st != ST_NORMAL);
    assign retry_slow  = (st == ST_WARN) || (st == ST_DERATE);
    assign cooldown_en = (st == ST_DERATE) && (rep_q >= cfg_rep_max);

    AST_COOLDOWN_IN_DERATE: assert property (@(posedge clk) disable iff (!rst_n)
        cooldown_en |-> retry_slow && effort_cap); // R9
endmodule

// File: tb/test_thermal_policy_ctrl.sv
module test_thermal_policy_ctrl;
    localparam int TW = 10, REP_W = 4, WIN_SMP = 8, HOLD_SMP = 3, STABLE_SMP = 4;
    localparam int LANES = 4, DER_L = 1, CYC_W = 8;
    localparam int WARN = 60, DERT = 80, RECV = 55, HYST = 5, LIM = 8, REPMAX = 4, DECAY = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, samp_vld;
    logic signed [TW-1:0] samp_temp;
    logic effort_cap, retry_slow, cooldown_en, evt_vld;
    logic [2:0] lane_cap;
    logic [1:0] state_o, evt_old, evt_new, evt_why;
    logic [CYC_W-1:0] derate_cycles;

    thermal_policy_ctrl #(.TW(TW), .REP_W(REP_W), .WIN_SMP(WIN_SMP), .HOLD_SMP(HOLD_SMP),
        .STABLE_SMP(STABLE_SMP), .LANES(LANES), .DERATE_LANES(DER_L), .CYC_W(CYC_W)) i_thermal_policy_ctrl (
        .clk, .rst_n, .samp_vld, .samp_temp,
        .cfg_warn(TW'(WARN)), .cfg_derate(TW'(DERT)), .cfg_recover(TW'(RECV)),
        .cfg_hyst(TW'(HYST)), .cfg_rise_lim(TW'(LIM)),
        .cfg_rep_max(REP_W'(REPMAX)), .cfg_decay_th(REP_W'(DECAY)),
        .effort_cap, .retry_slow, .lane_cap, .cooldown_en, .state_o, .derate_cycles,
        .evt_vld, .evt_old, .evt_new, .evt_why
    );

    int errs = 0, checks = 0;
    string cur_req = "R1";
    int m_state, m_prev, m_pvld, m_rep, m_win, m_hold, m_stab, m_lane, m_cyc;
    int m_evt, m_old, m_new, m_why;
    int lcg = 12345;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_prev = 0; m_pvld = 0; m_rep = 0; m_win = 0; m_hold = 0;
        m_stab = 0; m_lane = LANES; m_cyc = 0; m_evt = 0; m_old = 0; m_new = 0; m_why = 0;
    endtask

    task automatic model_update(int t);
        int rise, r, ns, why, h, s;
        bit trig, tick;
        rise = m_pvld ? t - m_prev : 0;
        trig = (t >= WARN) || (rise >= LIM);
        tick = (m_win == WIN_SMP - 1);
        r = m_rep;
        if (tick && r > 0) r--;
        if (trig && r < 15) r++;
        ns = m_state; why = 0;
        h = ((t <= RECV - HYST) && (rise < LIM)) ? m_hold + 1 : 0;
        s = (m_stab == STABLE_SMP) ? STABLE_SMP : m_stab + 1;
        case (m_state)
            0: if (t >= WARN) begin ns = 1; why = 0; end
               else if (rise >= LIM) begin ns = 1; why = 1; end
            1: if (t >= DERT) begin ns = 2; why = 0; end
               else if (r >= REPMAX) begin ns = 2; why = 2; end
               else if (t <= WARN - HYST) begin ns = 0; why = 0; end
            2: if (h == HOLD_SMP) begin ns = 3; why = 0; end
            default: if (t >= WARN) begin ns = 1; why = 0; end
               else if (rise > 0) begin ns = 1; why = 1; end
               else if (s == STABLE_SMP && r < DECAY) begin ns = 0; why = 3; end
        endcase
        m_win = ((ns == 1 && m_state != 1) || tick) ? 0 : m_win + 1;
        m_hold = (m_state == 2 && ns == 2) ? h : 0;
        m_stab = (m_state == 3 && ns == 3) ? s : 0;
        if (ns == 3 && m_state == 3) m_lane = (m_lane < LANES) ? m_lane + 1 : LANES;
        else if (ns == 3 || ns == 2) m_lane = DER_L;
        else m_lane = LANES;
        if (ns == 2 && m_state != 2 && m_cyc < 255) m_cyc++;
        m_evt = (ns != m_state);
        if (ns != m_state) begin m_old = m_state; m_new = ns; m_why = why; end
        m_state = ns; m_rep = r; m_prev = t; m_pvld = 1;
    endtask

    task automatic compare_all();
        chk(int'(state_o) == m_state, cur_req, "state", int'(state_o), m_state);
        chk(int'(lane_cap) == m_lane, "R9", "lane_cap", int'(lane_cap), m_lane);
        chk(effort_cap == (m_state != 0), "R9", "effort_cap", effort_cap, m_state != 0);
        chk(retry_slow == (m_state == 1 || m_state == 2), "R9", "retry_slow", retry_slow, m_state == 1 || m_state == 2);
        chk(cooldown_en == (m_state == 2 && m_rep >= REPMAX), "R9", "cooldown_en", cooldown_en, m_state == 2 && m_rep >= REPMAX);
        chk(int'(derate_cycles) == m_cyc, "R10", "derate_cycles", int'(derate_cycles), m_cyc);
        chk(int'(evt_vld) == m_evt, "R11", "evt_vld", evt_vld, m_evt);
        if (m_evt != 0) begin
            chk(int'(evt_old) == m_old, "R11", "evt_old", int'(evt_old), m_old);
            chk(int'(evt_new) == m_new, "R11", "evt_new", int'(evt_new), m_new);
            chk(int'(evt_why) == m_why, cur_req, "evt_why", int'(evt_why), m_why);
        end
    endtask

    task automatic step(bit v, int t);
        samp_vld = v;
        samp_temp = TW'(t);
        @(posedge clk);
        #1;
        if (v) model_update(t);
        else m_evt = 0;
        @(negedge clk);
        compare_all();
    endtask

    task automatic samples(int t, int n);
        for (int i = 0; i < n; i++) step(1'b1, t);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; samp_vld = 1'b0; samp_temp = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        compare_all();
        // R12: readings without samp_vld have no effect
        cur_req = "R12";
        for (int i = 0; i < 5; i++) step(1'b0, 99);
        // R2: level entry, first reading has zero rise
        cur_req = "R2";
        step(1'b1, 50); step(1'b1, 52); step(1'b1, 61);
        // R4: hysteresis exit
        cur_req = "R4";
        step(1'b1, 57); step(1'b1, 55);
        // R2: slope entry below the warning level
        cur_req = "R2";
        step(1'b1, 50); step(1'b1, 58);
        // R5: repeat escalation to derate
        cur_req = "R5";
        step(1'b1, 61); step(1'b1, 62); step(1'b1, 63);
        // R6: hold timer with an interruption
        cur_req = "R6";
        step(1'b1, 49); step(1'b1, 49); step(1'b1, 51);
        samples(49, 3);
        // R7: any rise in recovery
        cur_req = "R7";
        step(1'b1, 50);
        // R3: level escalation to derate
        cur_req = "R3";
        step(1'b1, 85);
        cur_req = "R6";
        samples(45, 3);
        // R8: stability timer and repeat decay
        cur_req = "R8";
        samples(45, 40);
        // R12: idle gap in the middle of activity
        cur_req = "R12";
        step(1'b1, 70);
        for (int i = 0; i < 4; i++) step(1'b0, 20);
        // R5: mixed walk with gaps to provoke simultaneous causes
        cur_req = "R5";
        for (int i = 0; i < 800; i++) begin
            int t;
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            t = 30 + ((lcg >>> 8) % 65);
            if (((lcg >>> 4) % 4) == 0) step(1'b0, t);
            else step(1'b1, t);
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule